// File: doc/BRIEF.md
# E1 CCS Timeslot Router

This block sits after an E1 receive framer. It picks the common-channel signalling octets out of the recovered PCM30 timeslots and places them on two serial TDM output streams, one for data and one for control. Each recovered octet arrives on a one-cycle strobe together with its receive timeslot number. Octets from timeslots 15, 16 and 31 are stored in a per-frame capture bank. In the following output frame they are shifted out one bit per clock, most significant bit first.

On the data stream each source keeps its own timeslot number. A source can also be copied to the control stream at a destination slot programmed for that source. At the 2.048 Mbit/s rate an output frame holds 32 slots. At the 8.192 Mbit/s rate it holds 128 slots, and a logical slot t maps to 4*t plus the framer index, so that four framers can interleave on one stream. The capture banks alternate every frame, which gives a fixed latency of one output frame. The configuration inputs are sampled only at frame boundaries.

Top module: `e1_ccs_router`

## Requirements
- R1: While reset is held and in the first cycle after it, `data_ser` and `ctrl_ser` are 1 and `frame_sync` is 1. The first two output frames run at the 2.048 Mbit/s length.
- R2: An output frame lasts 256 clocks at the base rate (`rate_fast`=0) and 1024 clocks at the fast rate (`rate_fast`=1). `frame_sync` is 1 only on the first bit of each frame.
- R3: While the captured CCS enable is 0, no octet is stored, and both streams carry all ones in the frame that follows.
- R4: Only receive timeslots 15, 16 and 31 are captured. An octet with any other timeslot number has no effect on either stream.
- R5: A captured octet from timeslot t appears on the data stream at output slot n + m*t.
- R6: Each of the three sources has its own copy enable: bit 0 for timeslot 15, bit 1 for 16, bit 2 for 31. When the bit is 1, the octet is also sent on the control stream at output slot n + m*d, where d is that source's 5-bit destination. When the bit is 0, that source leaves the control stream untouched.
- R7: At the base rate m=1 and n=0, and the framer index is ignored. At the fast rate m=4 and n is the 2-bit framer index, so the slots span 0..127.
- R8: `oct_data[7]` is the first bit received on the link. Within each output slot the serial order is `oct_data[7]` first and `oct_data[0]` last. Output slot s occupies frame bits 8*s to 8*s+7.
- R9: When two copied sources share a control destination, the octet from the higher-numbered source timeslot is sent.
- R10: Any output slot not written during the capture frame carries all ones, on both streams. The banks are emptied at every frame boundary.
- R11: Octets captured in output frame k are sent in frame k+1. The configuration that governs them is the one sampled at the start of frame k. That same sampled rate sets the length of frame k+1. Changes made to the inputs inside a frame have no effect until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the output streams |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_valid | input | 1 | One-cycle strobe for a recovered octet |
| oct_ts | input | 5 | Receive timeslot number of the octet |
| oct_data | input | 8 | Octet, bit 7 received first |
| ccs_enable | input | 1 | Enables signalling capture |
| copy_enable | input | 3 | Control-stream copy per source (bit0=TS15, bit1=TS16, bit2=TS31) |
| ctrl_dest_15 | input | 5 | Control-stream destination for timeslot 15 |
| ctrl_dest_16 | input | 5 | Control-stream destination for timeslot 16 |
| ctrl_dest_31 | input | 5 | Control-stream destination for timeslot 31 |
| rate_fast | input | 1 | 0: 32-slot frame, 1: 128-slot interleaved frame |
| framer_idx | input | 2 | Interleave position at the fast rate |
| data_ser | output | 1 | Serial data stream |
| ctrl_ser | output | 1 | Serial control stream |
| frame_sync | output | 1 | High on the first bit of each output frame |

## Verification
The assertions assume that `oct_valid` is a single-cycle pulse and that a frame never carries two octets with the same source timeslot. They also assume that the configuration inputs hold steady apart from deliberate changes inside a frame, which the boundary sampling must hide. The stimulus sends at most one octet per source in each frame. It places every strobe in the first few dozen clocks of a frame, well before the earliest boundary at clock 256, so no capture ever coincides with a bank swap. Glitches on the configuration inputs are applied and then removed within the same frame.

// File: rtl/ccs_router_pkg.sv
package ccs_router_pkg;
   localparam int TS_W   = 5;
   localparam int OCT_W  = 8;
   localparam int NSRC   = 3;
   localparam int FR_W   = 2;
   localparam int SLOT_W = TS_W + FR_W;
   localparam int CNT_W  = SLOT_W + 3;

   typedef logic [TS_W-1:0]   ts_t;
   typedef logic [SLOT_W-1:0] slot_t;

   // source timeslots, lowest priority first
   localparam logic [NSRC*TS_W-1:0] SRC_TS = {5'd31, 5'd16, 5'd15};

   // slot index n + m*t; with m = 2**FR_W this is a concatenation
   function automatic slot_t slot_of(input ts_t t, input logic fast,
                                     input logic [FR_W-1:0] fr);
      return fast ? {t, fr} : slot_t'(t);
   endfunction
endpackage

// File: rtl/ccs_cfg_stage.sv
module ccs_cfg_stage
   import ccs_router_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_end,
   input  logic                      in_ccs,
   input  logic [NSRC-1:0]           in_copy,
   input  logic [NSRC-1:0][TS_W-1:0] in_dest,
   input  logic                      in_fast,
   input  logic [FR_W-1:0]           in_framer,
   output logic                      wr_ccs,
   output logic [NSRC-1:0]           wr_copy,
   output logic [NSRC-1:0][TS_W-1:0] rd_dest,
   output logic                      rd_fast,
   output logic [FR_W-1:0]           rd_framer
);
   logic [NSRC-1:0][TS_W-1:0] wr_dest;
   logic                      wr_fast;
   logic [FR_W-1:0]           wr_framer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ccs    <= 1'b0;
         wr_copy   <= '0;
         wr_dest   <= '0;
         wr_fast   <= 1'b0;
         wr_framer <= '0;
         rd_dest   <= '0;
         rd_fast   <= 1'b0;
         rd_framer <= '0;
      end else if (frame_end) begin
         rd_dest   <= wr_dest;
         rd_fast   <= wr_fast;
         rd_framer <= wr_framer;
         wr_ccs    <= in_ccs;
         wr_copy   <= in_copy;
         wr_dest   <= in_dest;
         wr_fast   <= in_fast;
         wr_framer <= in_framer;
      end
   end

   assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> ($stable(wr_ccs) && $stable(wr_copy) && $stable(wr_dest)
                      && $stable(rd_dest) && $stable(rd_fast) && $stable(rd_framer)));

   assert_cfg_pipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (rd_fast == $past(wr_fast)) && (rd_dest == $past(wr_dest)));
endmodule

// File: rtl/ccs_capture.sv
module ccs_capture
   import ccs_router_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_end,
   input  logic                       wr_ccs,
   input  logic [NSRC-1:0]            wr_copy,
   input  logic                       oct_valid,
   input  logic [TS_W-1:0]            oct_ts,
   input  logic [OCT_W-1:0]           oct_data,
   output logic [NSRC-1:0][OCT_W-1:0] rd_oct,
   output logic [NSRC-1:0]            rd_dval,
   output logic [NSRC-1:0]            rd_cval
);
   logic [1:0][NSRC-1:0][OCT_W-1:0] oct_q;
   logic [1:0][NSRC-1:0]            dval_q;
   logic [1:0][NSRC-1:0]            cval_q;
   logic                            wr_sel;
   logic [NSRC-1:0]                 hit;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = oct_valid && wr_ccs && (oct_ts == SRC_TS[i*TS_W +: TS_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oct_q  <= '0;
         dval_q <= '0;
         cval_q <= '0;
         wr_sel <= 1'b0;
      end else begin
         for (int i = 0; i < NSRC; i++) begin
            if (hit[i]) begin
               oct_q[wr_sel][i]  <= oct_data;
               dval_q[wr_sel][i] <= 1'b1;
               cval_q[wr_sel][i] <= wr_copy[i];
            end
         end
         if (frame_end) begin
            dval_q[~wr_sel] <= '0;
            cval_q[~wr_sel] <= '0;
            wr_sel          <= ~wr_sel;
         end
      end
   end

   assign rd_oct  = oct_q[~wr_sel];
   assign rd_dval = dval_q[~wr_sel];
   assign rd_cval = cval_q[~wr_sel];

   logic is_src;
   assign is_src = (oct_ts == 5'd15) || (oct_ts == 5'd16) || (oct_ts == 5'd31);

   assert_ccs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_valid && !wr_ccs && !frame_end) |=> ($stable(dval_q) && $stable(oct_q)));

   assert_src_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_valid && !is_src && !frame_end) |=> ($stable(dval_q) && $stable(oct_q)));

   assert_copy_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_valid && !frame_end) |=>
         ((cval_q[wr_sel] & $past(hit) & ~$past(wr_copy)) == '0));

   assert_bank_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (dval_q[wr_sel] == '0) && (cval_q[wr_sel] == '0));
endmodule

// File: rtl/ccs_serializer.sv
module ccs_serializer
   import ccs_router_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSRC-1:0][TS_W-1:0]  rd_dest,
   input  logic                       rd_fast,
   input  logic [FR_W-1:0]            rd_framer,
   input  logic [NSRC-1:0][OCT_W-1:0] rd_oct,
   input  logic [NSRC-1:0]            rd_dval,
   input  logic [NSRC-1:0]            rd_cval,
   output logic                       data_ser,
   output logic                       ctrl_ser,
   output logic                       frame_sync,
   output logic                       frame_end
);
   localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'((1 << (TS_W + 3)) - 1);
   localparam logic [CNT_W-1:0] FAST_LAST = '1;

   logic [CNT_W-1:0] cnt;
   slot_t            slot;
   logic [2:0]       bsel;
   logic [NSRC-1:0]  dhit, chit;

   assign frame_end  = (cnt == (rd_fast ? FAST_LAST : BASE_LAST));
   assign frame_sync = (cnt == '0);
   assign slot       = cnt[CNT_W-1:3];
   assign bsel       = cnt[2:0];

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (frame_end) cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_hit
      assign dhit[i] = rd_dval[i] &&
         (slot == slot_of(SRC_TS[i*TS_W +: TS_W], rd_fast, rd_framer));
      assign chit[i] = rd_cval[i] &&
         (slot == slot_of(rd_dest[i], rd_fast, rd_framer));
   end

   // ascending scan: the last match, the highest source, wins
   always_comb begin
      data_ser = 1'b1;
      ctrl_ser = 1'b1;
      for (int i = 0; i < NSRC; i++) begin
         if (dhit[i]) data_ser = rd_oct[i][3'(OCT_W-1) - bsel];
         if (chit[i]) ctrl_ser = rd_oct[i][3'(OCT_W-1) - bsel];
      end
   end

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> frame_sync);

   assert_data_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ser |-> (|rd_dval));

   assert_ctrl_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_ser |-> (|rd_cval));

   assert_data_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dhit));
endmodule

// File: rtl/e1_ccs_router.sv
module e1_ccs_router
   import ccs_router_pkg::*;
#(
   parameter int MUX = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        oct_valid,
   input  logic [4:0]  oct_ts,
   input  logic [7:0]  oct_data,
   input  logic        ccs_enable,
   input  logic [2:0]  copy_enable,
   input  logic [4:0]  ctrl_dest_15,
   input  logic [4:0]  ctrl_dest_16,
   input  logic [4:0]  ctrl_dest_31,
   input  logic        rate_fast,
   input  logic [1:0]  framer_idx,
   output logic        data_ser,
   output logic        ctrl_ser,
   output logic        frame_sync
);
   if (MUX != (1 << FR_W)) begin : g_bad_mux
      $error("MUX must equal 2**FR_W");
   end
   if (OCT_W != 8 || TS_W != 5 || NSRC != 3) begin : g_bad_shape
      $error("port widths assume 8-bit octets, 5-bit timeslots, three sources");
   end

   logic                       frame_end;
   logic                       wr_ccs;
   logic [NSRC-1:0]            wr_copy;
   logic [NSRC-1:0][TS_W-1:0]  rd_dest;
   logic                       rd_fast;
   logic [FR_W-1:0]            rd_framer;
   logic [NSRC-1:0][OCT_W-1:0] rd_oct;
   logic [NSRC-1:0]            rd_dval, rd_cval;

   ccs_cfg_stage u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .in_ccs    (ccs_enable),
      .in_copy   (copy_enable),
      .in_dest   ({ctrl_dest_31, ctrl_dest_16, ctrl_dest_15}),
      .in_fast   (rate_fast),
      .in_framer (framer_idx),
      .wr_ccs    (wr_ccs),
      .wr_copy   (wr_copy),
      .rd_dest   (rd_dest),
      .rd_fast   (rd_fast),
      .rd_framer (rd_framer)
   );

   ccs_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .wr_ccs    (wr_ccs),
      .wr_copy   (wr_copy),
      .oct_valid (oct_valid),
      .oct_ts    (oct_ts),
      .oct_data  (oct_data),
      .rd_oct    (rd_oct),
      .rd_dval   (rd_dval),
      .rd_cval   (rd_cval)
   );

   ccs_serializer u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_dest    (rd_dest),
      .rd_fast    (rd_fast),
      .rd_framer  (rd_framer),
      .rd_oct     (rd_oct),
      .rd_dval    (rd_dval),
      .rd_cval    (rd_cval),
      .data_ser   (data_ser),
      .ctrl_ser   (ctrl_ser),
      .frame_sync (frame_sync),
      .frame_end  (frame_end)
   );

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (data_ser && ctrl_ser && frame_sync));
endmodule

// File: tb/tb_e1_ccs_router.sv
`timescale 1ns/1ps
module tb_e1_ccs_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oct_valid = 1'b0;
   logic [4:0] oct_ts = '0;
   logic [7:0] oct_data = '0;
   logic       ccs_enable = 1'b0;
   logic [2:0] copy_enable = '0;
   logic [4:0] ctrl_dest_15 = '0, ctrl_dest_16 = '0, ctrl_dest_31 = '0;
   logic       rate_fast = 1'b0;
   logic [1:0] framer_idx = '0;
   logic       data_ser, ctrl_ser, frame_sync;

   always #2.5 clk = ~clk;

   e1_ccs_router dut (.*);

   typedef struct {
      bit ccs; bit [2:0] cp; bit [4:0] d15, d16, d31; bit fast; bit [1:0] fr;
   } bcfg_t;
   typedef struct {
      int fr; int len; logic [1023:0] d; logic [1023:0] c; string tag;
   } item_t;

   item_t      q[$];
   bcfg_t      prev;
   int         dfr = -1;
   logic [4:0] pts[$];
   logic [7:0] pdat[$];
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic put(inout logic [1023:0] v, input int s, input logic [7:0] val);
      for (int b = 0; b < 8; b++) v[s*8+b] = val[7-b];
   endtask

   task automatic apply_live(bcfg_t c);
      ccs_enable = c.ccs; copy_enable = c.cp; rate_fast = c.fast; framer_idx = c.fr;
      ctrl_dest_15 = c.d15; ctrl_dest_16 = c.d16; ctrl_dest_31 = c.d31;
   endtask

   // called at the start of a frame: queued octets are governed by prev
   task automatic run_frame(bcfg_t nxt, string tag, bit glitch);
      item_t it;
      int m, n, t;
      bit found;
      logic [7:0] val;
      logic [4:0] dst;
      do @(negedge clk); while (!frame_sync);
      dfr++;
      it.fr = dfr + 1; it.tag = tag; it.d = '1; it.c = '1;
      it.len = prev.fast ? 1024 : 256;
      m = prev.fast ? 4 : 1;
      n = prev.fast ? int'(prev.fr) : 0;
      for (int k = 0; k < 3; k++) begin
         t = (k == 0) ? 15 : (k == 1) ? 16 : 31;
         dst = (k == 0) ? prev.d15 : (k == 1) ? prev.d16 : prev.d31;
         found = 0; val = '0;
         foreach (pts[j]) if (int'(pts[j]) == t) begin val = pdat[j]; found = 1; end
         if (prev.ccs && found) begin
            put(it.d, n + m*t, val);
            if (prev.cp[k]) put(it.c, n + m*int'(dst), val);
         end
      end
      q.push_back(it);
      if (glitch) begin
         ccs_enable = ~nxt.ccs; rate_fast = ~nxt.fast; copy_enable = ~nxt.cp;
         repeat (10) @(negedge clk);
      end
      apply_live(nxt);
      foreach (pts[j]) begin
         @(negedge clk); oct_valid = 1; oct_ts = pts[j]; oct_data = pdat[j];
         @(negedge clk); oct_valid = 0;
      end
      prev = nxt;
      pts.delete(); pdat.delete();
   endtask

   // monitor: collects each frame and compares it against the scoreboard
   initial begin
      int mfr = -1, pos = 0;
      bit active = 0;
      item_t cur;
      logic [1023:0] gd, gc;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (frame_sync) begin
            if (active) begin
               check(pos == cur.len, "R2", $sformatf("frame %0d length", cur.fr), pos, cur.len);
               for (int i = cur.len; i < 1024; i++) begin gd[i] = 1'b1; gc[i] = 1'b1; end
               for (int s = 0; s < cur.len/8; s++)
                  if (gd[s*8 +: 8] !== cur.d[s*8 +: 8] || gc[s*8 +: 8] !== cur.c[s*8 +: 8]) begin
                     $display("  frame %0d first differing slot %0d", cur.fr, s);
                     break;
                  end
               check(gd === cur.d, cur.tag, $sformatf("frame %0d data stream low word", cur.fr),
                     gd[63:0] ^ cur.d[63:0], 0);
               check(gc === cur.c, cur.tag, $sformatf("frame %0d ctrl stream low word", cur.fr),
                     gc[63:0] ^ cur.c[63:0], 0);
            end
            mfr++; active = 0; pos = 0;
            if (q.size() > 0 && q[0].fr == mfr) begin cur = q.pop_front(); active = 1; end
         end
         if (active && pos < 1024) begin gd[pos] = data_ser; gc[pos] = ctrl_ser; end
         pos++;
      end
   end

   initial begin
      #(200000 * 5);
      check(0, "WATCHDOG", "run did not complete", 0, 1);
      finish_run();
   end

   initial begin
      bcfg_t a, b, c, d, e;
      prev = '{default: 0};
      repeat (4) @(negedge clk);
      check(data_ser === 1'b1, "R1", "data_ser in reset", data_ser, 1);
      check(ctrl_ser === 1'b1, "R1", "ctrl_ser in reset", ctrl_ser, 1);
      check(frame_sync === 1'b1, "R1", "frame_sync in reset", frame_sync, 1);
      @(posedge clk); #1 rst_n = 1'b1;

      a = '{ccs:1, cp:3'b101, d15:5'd3, d16:5'd9, d31:5'd20, fast:0, fr:2'd2};
      b = '{ccs:1, cp:3'b111, d15:5'd7, d16:5'd7, d31:5'd7, fast:1, fr:2'd1};
      c = '{ccs:1, cp:3'b011, d15:5'd0, d16:5'd31, d31:5'd5, fast:1, fr:2'd3};
      d = '{ccs:0, cp:3'b111, d15:5'd1, d16:5'd2, d31:5'd3, fast:1, fr:2'd0};
      e = '{ccs:1, cp:3'b010, d15:5'd4, d16:5'd16, d31:5'd8, fast:0, fr:2'd1};

      // frame 0: reset config has capture off (R1 R3 R11)
      pts = '{5'd15}; pdat = '{8'h12};
      run_frame(a, "R1 R3 R11", 0);
      // frame 1: base rate, copies for 15 and 31, non-source ts ignored, glitch hidden
      pts = '{5'd15, 5'd5, 5'd16, 5'd31}; pdat = '{8'hA5, 8'h00, 8'h3C, 8'h81};
      run_frame(b, "R4 R5 R6 R7 R8 R11", 1);
      // frame 2: fast rate framer 1, three copies collide on one slot
      pts = '{5'd31, 5'd16, 5'd15}; pdat = '{8'hC3, 8'h5A, 8'h0F};
      run_frame(c, "R5 R7 R9", 0);
      // frame 3: fast rate framer 3, reaching the top slot 127
      pts = '{5'd16, 5'd15, 5'd31}; pdat = '{8'h96, 8'h71, 8'hE8};
      run_frame(d, "R6 R7 R8", 0);
      // frame 4: capture disabled at fast rate
      pts = '{5'd15, 5'd16, 5'd31}; pdat = '{8'h00, 8'h00, 8'h00};
      run_frame(e, "R3", 0);
      // frame 5: single zero octet copied to the same slot number
      pts = '{5'd16}; pdat = '{8'h00};
      run_frame(e, "R6 R8", 0);
      // frame 6: nothing sent, banks must read back as idle
      run_frame(e, "R10", 0);

      repeat (2) begin do @(negedge clk); while (!frame_sync); end
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R11", "frames left unchecked", q.size(), 0);
      finish_run();
   end
endmodule